// File: doc/BRIEF.md
# Narrow-to-Wide Bus Width Adapter

This block joins a 32-bit bus master that issues byte addresses to a 64-bit, word-addressed memory-like slave that is 512 words deep. The slave's address port holds a word index, so each slave word takes eight bytes of the master's address space, and the whole slave fills a 4096-byte window. The adapter takes the word index from the master's byte address. One address bit picks which 32-bit half of the 64-bit word an access touches.

On a write, the master data is copied onto both halves of the wide write bus. The master's four byte enables are placed in the lane group of the selected half, and the other group is held at zero. A 64-bit slave word is therefore filled by two consecutive 32-bit writes. On a read, the slave answers one cycle later. The adapter registers the half select together with a valid flag and returns the matching 32 bits to the master. The adapter does not decode the window: the lowest two address bits and all bits above the window are ignored.

Top module: `nw_bridge`

## Requirements
- R1: The slave word address `s_addr` equals master address bits [11:3] in the same cycle.
- R2: During a write with master address bit 2 clear, `s_be[3:0]` equals `m_be` and `s_be[7:4]` is zero.
- R3: During a write with master address bit 2 set, `s_be[7:4]` equals `m_be` and `s_be[3:0]` is zero.
- R4: `s_wdata[63:32]` and `s_wdata[31:0]` both equal `m_wdata`.
- R5: For a read, the data returned in the following cycle is slave bits [63:32] if address bit 2 was set and bits [31:0] if it was clear.
- R6: `m_rvalid` is low after reset. It is high in exactly the cycle after a cycle with `m_read` high, and low otherwise.
- R7: Master address bits [1:0] have no effect on the word addressed, the half selected, or the data moved.
- R8: `s_be` is all zero whenever `m_write` is low. `s_read` and `s_write` follow `m_read` and `m_write` in the same cycle.
- R9: Two 32-bit writes to byte addresses 8k and 8k+4 fill the lower and upper halves of slave word k, and both halves read back unchanged.
- R10: Master address bits above bit 11 do not change the slave word address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_addr | input | 16 | Master byte address |
| m_read | input | 1 | Master read strobe |
| m_write | input | 1 | Master write strobe |
| m_be | input | 4 | Master byte enables |
| m_wdata | input | 32 | Master write data |
| m_rdata | output | 32 | Read data returned to the master |
| m_rvalid | output | 1 | Read data valid, one cycle after the read |
| s_addr | output | 9 | Slave word address |
| s_read | output | 1 | Slave read strobe |
| s_write | output | 1 | Slave write strobe |
| s_be | output | 8 | Slave byte enables |
| s_wdata | output | 64 | Slave write data |
| s_rdata | input | 64 | Slave read data, one cycle latency |

## Verification
The lane steering is driven with full, partial and split byte-enable patterns on both halves. Writing a partial mask over a known full word shows whether the bytes outside the mask stay untouched. Lower and upper halves of one word are written with different data and read back. This catches a swapped or stuck half select and wrong read muxing. It also catches a word index taken from the wrong bits. Addresses with junk in bits [1:0] and above bit 11 are compared against clean aliases to show that those bits are ignored. Reads issued back to back and after idle cycles test the valid timing.

// File: rtl/nw_pkg.sv
package nw_pkg;
  localparam int DEF_M_ADDR_W = 16;
  localparam int DEF_M_DATA_W = 32;
  localparam int DEF_S_DATA_W = 64;
  localparam int DEF_S_WORDS  = 512;
endpackage

// File: rtl/nw_addr_xlate.sv
module nw_addr_xlate #(
  parameter int M_ADDR_W = 16,
  parameter int S_ADDR_W = 9,
  parameter int S_OFF_W  = 3,
  parameter int M_OFF_W  = 2,
  parameter int SEL_W    = 1
) (
  input  logic [M_ADDR_W-1:0] m_addr,
  output logic [S_ADDR_W-1:0] s_addr,
  output logic [SEL_W-1:0]    lane_sel
);
  // bits below the master offset and above the window are not decoded
  logic unused_addr;
  assign unused_addr = ^m_addr;

  assign s_addr   = m_addr[S_OFF_W +: S_ADDR_W];
  assign lane_sel = m_addr[M_OFF_W +: SEL_W];
endmodule

// File: rtl/nw_wr_steer.sv
module nw_wr_steer #(
  parameter int M_DATA_W = 32,
  parameter int RATIO    = 2,
  parameter int SEL_W    = 1
) (
  input  logic                        m_write,
  input  logic [SEL_W-1:0]            lane_sel,
  input  logic [M_DATA_W/8-1:0]       m_be,
  input  logic [M_DATA_W-1:0]         m_wdata,
  output logic [RATIO*M_DATA_W/8-1:0] s_be,
  output logic [RATIO*M_DATA_W-1:0]   s_wdata
);
  localparam int M_BE_W = M_DATA_W / 8;

  for (genvar g = 0; g < RATIO; g++) begin : g_lane
    assign s_wdata[g*M_DATA_W +: M_DATA_W] = m_wdata;
    assign s_be[g*M_BE_W +: M_BE_W] =
      (m_write && (lane_sel == SEL_W'(g))) ? m_be : '0;
  end
endmodule

// File: rtl/nw_rd_return.sv
module nw_rd_return #(
  parameter int M_DATA_W = 32,
  parameter int RATIO    = 2,
  parameter int SEL_W    = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      m_read,
  input  logic [SEL_W-1:0]          lane_sel,
  input  logic [RATIO*M_DATA_W-1:0] s_rdata,
  output logic [M_DATA_W-1:0]       m_rdata,
  output logic                      m_rvalid
);
  logic [SEL_W-1:0]    sel_q;
  logic                vld_q;
  logic [M_DATA_W-1:0] lanes [RATIO];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      sel_q <= '0;
    end else begin
      vld_q <= m_read;
      if (m_read) sel_q <= lane_sel;
    end
  end

  for (genvar g = 0; g < RATIO; g++) begin : g_half
    assign lanes[g] = s_rdata[g*M_DATA_W +: M_DATA_W];
  end

  assign m_rdata  = lanes[sel_q];
  assign m_rvalid = vld_q;
endmodule

// File: rtl/nw_bridge.sv
module nw_bridge
  import nw_pkg::*;
#(
  parameter int M_ADDR_W = DEF_M_ADDR_W,
  parameter int M_DATA_W = DEF_M_DATA_W,
  parameter int S_DATA_W = DEF_S_DATA_W,
  parameter int S_WORDS  = DEF_S_WORDS
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [M_ADDR_W-1:0]         m_addr,
  input  logic                        m_read,
  input  logic                        m_write,
  input  logic [M_DATA_W/8-1:0]       m_be,
  input  logic [M_DATA_W-1:0]         m_wdata,
  output logic [M_DATA_W-1:0]         m_rdata,
  output logic                        m_rvalid,
  output logic [$clog2(S_WORDS)-1:0]  s_addr,
  output logic                        s_read,
  output logic                        s_write,
  output logic [S_DATA_W/8-1:0]       s_be,
  output logic [S_DATA_W-1:0]         s_wdata,
  input  logic [S_DATA_W-1:0]         s_rdata
);
  localparam int RATIO    = S_DATA_W / M_DATA_W;
  localparam int SEL_W    = $clog2(RATIO);
  localparam int S_ADDR_W = $clog2(S_WORDS);
  localparam int M_OFF_W  = $clog2(M_DATA_W / 8);
  localparam int S_OFF_W  = $clog2(S_DATA_W / 8);

  logic [SEL_W-1:0] lane_sel;

  nw_addr_xlate #(
    .M_ADDR_W(M_ADDR_W), .S_ADDR_W(S_ADDR_W), .S_OFF_W(S_OFF_W),
    .M_OFF_W(M_OFF_W), .SEL_W(SEL_W)
  ) u_xlate (
    .m_addr(m_addr), .s_addr(s_addr), .lane_sel(lane_sel)
  );

  nw_wr_steer #(
    .M_DATA_W(M_DATA_W), .RATIO(RATIO), .SEL_W(SEL_W)
  ) u_steer (
    .m_write(m_write), .lane_sel(lane_sel), .m_be(m_be),
    .m_wdata(m_wdata), .s_be(s_be), .s_wdata(s_wdata)
  );

  nw_rd_return #(
    .M_DATA_W(M_DATA_W), .RATIO(RATIO), .SEL_W(SEL_W)
  ) u_ret (
    .clk(clk), .rst(rst), .m_read(m_read), .lane_sel(lane_sel),
    .s_rdata(s_rdata), .m_rdata(m_rdata), .m_rvalid(m_rvalid)
  );

  assign s_read  = m_read;
  assign s_write = m_write;
endmodule

// File: rtl/nw_bridge_chk.sv
module nw_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] m_addr,
  input logic        m_read,
  input logic        m_write,
  input logic [3:0]  m_be,
  input logic [31:0] m_wdata,
  input logic [31:0] m_rdata,
  input logic        m_rvalid,
  input logic        s_write,
  input logic [7:0]  s_be,
  input logic [63:0] s_wdata,
  input logic [63:0] s_rdata
);
  // R2
  low_half_be_chk: assert property (@(posedge clk) disable iff (rst)
    (m_write && !m_addr[2]) |-> (s_be[7:4] == 4'h0 && s_be[3:0] == m_be));

  // R3
  high_half_be_chk: assert property (@(posedge clk) disable iff (rst)
    (m_write && m_addr[2]) |-> (s_be[3:0] == 4'h0 && s_be[7:4] == m_be));

  // R4
  wdata_copy_chk: assert property (@(posedge clk) disable iff (rst)
    m_write |-> (s_wdata[63:32] == m_wdata && s_wdata[31:0] == m_wdata));

  // R5
  rdata_half_chk: assert property (@(posedge clk) disable iff (rst)
    m_rvalid |-> (m_rdata == ($past(m_addr[2]) ? s_rdata[63:32] : s_rdata[31:0])));

  // R6
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    m_read |=> m_rvalid);

  // R6
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !m_read |=> !m_rvalid);

  // R8
  idle_be_chk: assert property (@(posedge clk) disable iff (rst)
    !s_write |-> (s_be == 8'h00));
endmodule

bind nw_bridge nw_bridge_chk u_chk (
  .clk(clk), .rst(rst), .m_addr(m_addr), .m_read(m_read),
  .m_write(m_write), .m_be(m_be), .m_wdata(m_wdata), .m_rdata(m_rdata),
  .m_rvalid(m_rvalid), .s_write(s_write), .s_be(s_be),
  .s_wdata(s_wdata), .s_rdata(s_rdata)
);

// File: tb/nw_bridge_bench.sv
`timescale 1ns/1ps
module nw_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] m_addr = '0;
  logic        m_read = 1'b0;
  logic        m_write = 1'b0;
  logic [3:0]  m_be = '0;
  logic [31:0] m_wdata = '0;
  logic [31:0] m_rdata;
  logic        m_rvalid;
  logic [8:0]  s_addr;
  logic        s_read;
  logic        s_write;
  logic [7:0]  s_be;
  logic [63:0] s_wdata;
  logic [63:0] s_rdata;

  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  nw_bridge u_nw_bridge (
    .clk(clk), .rst(rst), .m_addr(m_addr), .m_read(m_read),
    .m_write(m_write), .m_be(m_be), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_rvalid(m_rvalid), .s_addr(s_addr),
    .s_read(s_read), .s_write(s_write), .s_be(s_be),
    .s_wdata(s_wdata), .s_rdata(s_rdata)
  );

  // slave model: 512 x 64 with byte enables, one cycle read latency
  logic [63:0] mem [512];
  logic [63:0] rd_q = '0;
  initial for (int i = 0; i < 512; i++) mem[i] = '0;
  always @(posedge clk) begin
    if (s_write)
      for (int b = 0; b < 8; b++)
        if (s_be[b]) mem[s_addr][b*8 +: 8] <= s_wdata[b*8 +: 8];
    if (s_read) rd_q <= mem[s_addr];
  end
  assign s_rdata = rd_q;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    m_read = 1'b0; m_write = 1'b0; m_be = '0;
  endtask

  task automatic put_write(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    m_addr = a; m_be = be; m_wdata = d; m_write = 1'b1; m_read = 1'b0;
    #1;
  endtask

  task automatic read_back(input logic [15:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    m_addr = a; m_read = 1'b1; m_write = 1'b0;
    @(negedge clk);
    v = m_rvalid; d = m_rdata;
    m_read = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 rvalid in reset", 64'(m_rvalid), 64'd0);
    chk("R8 be idle", 64'(s_be), 64'd0);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R6 rvalid after reset", 64'(m_rvalid), 64'd0);
  endtask

  task automatic t_addr_map();
    logic [15:0] al [4] = '{16'h0000, 16'h0FF8, 16'hF123, 16'h8ABC};
    foreach (al[i]) begin
      @(negedge clk); m_addr = al[i]; #1;
      chk("R1 R10 word address", 64'(s_addr), 64'((al[i] & 16'h0FFF) >> 3));
      chk("R8 strobes idle", 64'({s_read, s_write, s_be}), 64'd0);
    end
  endtask

  task automatic t_write_lanes();
    put_write(16'h0010, 4'b0110, 32'hA5A5_1234);
    chk("R2 low lane be", 64'(s_be), 64'h06);
    chk("R4 write data copy", s_wdata, 64'hA5A5_1234_A5A5_1234);
    chk("R8 write strobe", 64'({s_write, s_read}), 64'b10);
    put_write(16'h0014, 4'hF, 32'h0BAD_CAFE);
    chk("R3 high lane be", 64'(s_be), 64'hF0);
    chk("R4 write data copy high", s_wdata, 64'h0BAD_CAFE_0BAD_CAFE);
    idle();
    #1 chk("R8 be after write", 64'(s_be), 64'd0);
  endtask

  task automatic t_pair();
    logic [31:0] d; logic v;
    put_write(16'h0100, 4'hF, 32'h1122_3344);
    put_write(16'h0104, 4'hF, 32'h5566_7788);
    idle();
    chk("R9 stored word", mem[9'h20], 64'h5566_7788_1122_3344);
    read_back(16'h0100, d, v);
    chk("R6 valid low read", 64'(v), 64'd1);
    chk("R5 R9 low half", 64'(d), 64'h1122_3344);
    read_back(16'h0104, d, v);
    chk("R5 R9 high half", 64'(d), 64'h5566_7788);
    @(negedge clk);
    chk("R6 valid drops", 64'(m_rvalid), 64'd0);
  endtask

  task automatic t_partial();
    logic [31:0] d; logic v;
    put_write(16'h0200, 4'hF, 32'hFFFF_FFFF);
    put_write(16'h0204, 4'hF, 32'hFFFF_FFFF);
    put_write(16'h0204, 4'b0011, 32'h0000_ABCD);
    chk("R3 partial high be", 64'(s_be), 64'h30);
    put_write(16'h0200, 4'b1000, 32'h1200_0000);
    chk("R2 partial low be", 64'(s_be), 64'h08);
    idle();
    read_back(16'h0204, d, v);
    chk("R3 partial merge high", 64'(d), 64'hFFFF_ABCD);
    read_back(16'h0200, d, v);
    chk("R2 partial merge low", 64'(d), 64'h12FF_FFFF);
  endtask

  task automatic t_low_bits();
    logic [31:0] d; logic v;
    put_write(16'h030B, 4'hF, 32'hCAFE_F00D);
    chk("R7 word address", 64'(s_addr), 64'h61);
    chk("R7 lane be", 64'(s_be), 64'h0F);
    idle();
    read_back(16'h0309, d, v);
    chk("R7 read low alias", 64'(d), 64'hCAFE_F00D);
    read_back(16'h030D, d, v);
    chk("R7 read high alias", 64'(d), 64'h0);
    read_back(16'h7308, d, v);
    chk("R10 high bits alias", 64'(d), 64'hCAFE_F00D);
  endtask

  task automatic t_back_to_back();
    @(negedge clk); m_addr = 16'h0104; m_read = 1'b1;
    @(negedge clk);
    chk("R6 b2b first valid", 64'(m_rvalid), 64'd1);
    chk("R5 b2b first data", 64'(m_rdata), 64'h5566_7788);
    m_addr = 16'h0100;
    @(negedge clk);
    chk("R6 b2b second valid", 64'(m_rvalid), 64'd1);
    chk("R5 b2b second data", 64'(m_rdata), 64'h1122_3344);
    m_read = 1'b0;
    @(negedge clk);
    chk("R6 b2b valid ends", 64'(m_rvalid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_addr_map();
    t_write_lanes();
    t_pair();
    t_partial();
    t_low_bits();
    t_back_to_back();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule